// File: doc/BRIEF.md
# Event Timestamp Capture Latch

This block records the time at which an external event occurs. An asynchronous event pin is brought into the clock domain and edge-detected. On each rising edge the block copies the current time into a single-entry timestamp register. The time is either the full set of calendar fields or the free-running seconds count, and a mode input chooses which. Each capture sets a timestamp flag, which drives a level interrupt.

The time source presents its fields with a tick strobe. The block keeps a shadow copy that is loaded only on tick cycles, so a capture never mixes fields from two different seconds. The register holds one entry only. A further event that arrives while the flag is still set is an overrun: it sets a sticky overrun bit, and a policy input decides whether the stored value is kept or replaced by the newest one.

Software reads the status word first. That read also freezes a read snapshot of the stamp. It then reads the fields from the snapshot and finally pulses the clear input. A clear that lands in the same cycle as a new capture keeps the new capture.

Top module: `evt_stamp_latch`

## Requirements
- R1: After synchronous reset, irq is 0, the status word reads 0 and every field address reads 0.
- R2: A rising edge on evt_in sets the flag and irq on exactly the third rising clock edge after the change (two synchronizer stages plus one edge-detect register). Holding evt_in high produces only one capture.
- R3: With full_cal=1 the stamp is the calendar bus. With full_cal=0 it is sec_cnt in the low SEC_W bits with the upper bits zero. Status bit 2 records which of the two was captured (1 = calendar).
- R4: Captured values come from the copy taken at the most recent cycle with tick=1. Changes on cal_bus or sec_cnt without a tick are not captured.
- R5: irq equals the timestamp flag and stays high until a clear.
- R6: With keep_latest=0, an event that occurs while the flag is set leaves the stored stamp unchanged.
- R7: With keep_latest=1, an event that occurs while the flag is set replaces the stamp with the new time.
- R8: An event that occurs while the flag is set, with no clear in the same cycle, sets status bit 1 (overrun). The overrun bit stays set until a clr pulse, and clr clears both status bit 0 (flag) and status bit 1.
- R9: When clr coincides with a capture, the flag stays set, overrun reads 0 and the new value is stored.
- R10: A read presents rd_data on the cycle after rd_en. Address 0 returns the status word and copies the stamp into a snapshot. Address k in 1..NUM_FIELDS returns snapshot field k-1, where field 0 is the least significant FIELD_W bits. Higher addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 1 | Asynchronous event pin, rising edge captures |
| tick | input | 1 | Strobe marking a cycle in which the time inputs are valid and new |
| cal_bus | input | NUM_FIELDS*FIELD_W | Calendar fields, field 0 in the low bits |
| sec_cnt | input | SEC_W | Free-running seconds count |
| full_cal | input | 1 | 1: capture calendar fields, 0: capture seconds count |
| keep_latest | input | 1 | Overrun policy: 1 overwrite, 0 keep first |
| clr | input | 1 | Clears the flag and the overrun bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | $clog2(NUM_FIELDS+1) | Read word address |
| rd_data | output | FIELD_W | Read data, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
The assertions check the relationships that hold on every cycle:
- the flag never rises without a capture pulse in the cycle before;
- the overrun bit is never set without the flag;
- a clear empties both bits unless it collides with a capture;
- under the keep-first policy the stored stamp does not move while the flag is set;
- the shadow copy and the read snapshot move only on a tick or a status read.

The bench scenarios cover what depends on the values themselves:
- the exact three-edge latency;
- correct calendar or seconds content with a deliberately unstable bus between ticks;
- the old-versus-new stamp under each policy;
- snapshot isolation while an overwrite happens mid-read;
- the clear/capture collision.

// File: rtl/ts_pkg.sv
// Shared constants for the event timestamp latch.
// Assumes the status word is at least three bits wide.
package ts_pkg;
    // Status word bit positions (software decodes these).
    localparam int ST_FLAG_BIT = 0;
    localparam int ST_OVR_BIT  = 1;
    localparam int ST_MODE_BIT = 2;

    // Overrun policy encoding as seen on the keep_latest pin.
    typedef enum logic {
        POL_KEEP_FIRST  = 1'b0,
        POL_KEEP_LATEST = 1'b1
    } ovr_policy_e;
endpackage

// File: rtl/ts_evt_sync.sv
// Brings an asynchronous event pin into the clock domain and emits a
// one-cycle pulse on each rising edge. Assumes SYNC_STAGES >= 2.
// Pin-to-pulse latency is SYNC_STAGES edges; the pulse acts at the next edge.
module ts_evt_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_async,
    output logic evt_rise
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain_q;
    logic         seen_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[MSB-1:0], evt_async};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= chain_q[MSB];
    end

    // Rising edge of the synchronized level.
    assign evt_rise = chain_q[MSB] & ~seen_q;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rise |=> !evt_rise);
endmodule

// File: rtl/ts_tick_shadow.sv
// Holds a copy of the time inputs taken only in tick cycles, so a capture
// always sees one coherent second. Assumes the source fields are valid
// whenever tick is high.
module ts_tick_shadow #(
    parameter int STAMP_W = 48,
    parameter int SEC_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [STAMP_W-1:0] cal_bus,
    input  logic [SEC_W-1:0]   sec_cnt,
    output logic [STAMP_W-1:0] cal_shadow,
    output logic [SEC_W-1:0]   sec_shadow
);
    // Load both shadows together on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_shadow <= '0;
            sec_shadow <= '0;
        end else if (tick) begin
            cal_shadow <= cal_bus;
            sec_shadow <= sec_cnt;
        end
    end

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cal_shadow) && $stable(sec_shadow)));
endmodule

// File: rtl/ts_stamp_store.sv
// Single-entry timestamp register with flag, sticky overrun and policy.
// Assumes cap is a one-cycle pulse. A clear that coincides with a capture
// is treated as freeing the entry first, so the capture is fresh.
module ts_stamp_store
    import ts_pkg::*;
#(
    parameter int STAMP_W = 48,
    parameter int SEC_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic               clr,
    input  logic               keep_latest,
    input  logic               full_cal,
    input  logic [STAMP_W-1:0] cal_shadow,
    input  logic [SEC_W-1:0]   sec_shadow,
    output logic               flag,
    output logic               ovr,
    output logic               mode_full,
    output logic [STAMP_W-1:0] stamp
);
    logic [STAMP_W-1:0] sec_wide;
    logic [STAMP_W-1:0] new_val;
    ovr_policy_e        policy;
    logic               entry_free;

    // Widen the seconds count to the stamp width.
    generate
        if (SEC_W < STAMP_W) begin : g_pad
            assign sec_wide = {{(STAMP_W-SEC_W){1'b0}}, sec_shadow};
        end else begin : g_trunc
            assign sec_wide = sec_shadow[STAMP_W-1:0];
        end
    endgenerate

    // Pick the content to store and decode the policy.
    assign new_val    = full_cal ? cal_shadow : sec_wide;
    assign policy     = ovr_policy_e'(keep_latest);
    assign entry_free = !flag || clr;

    // Capture, overrun and clear handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag      <= 1'b0;
            ovr       <= 1'b0;
            mode_full <= 1'b0;
            stamp     <= '0;
        end else if (cap) begin
            if (entry_free) begin
                flag      <= 1'b1;
                ovr       <= 1'b0;
                stamp     <= new_val;
                mode_full <= full_cal;
            end else begin
                ovr <= 1'b1;
                if (policy == POL_KEEP_LATEST) begin
                    stamp     <= new_val;
                    mode_full <= full_cal;
                end
            end
        end else if (clr) begin
            flag <= 1'b0;
            ovr  <= 1'b0;
        end
    end

    // R2
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cap));
    // R6
    keep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !keep_latest) |=> $stable(stamp));
    // R8
    ovr_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> flag);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cap) |=> (!flag && !ovr));
    // R9
    clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && cap) |=> (flag && !ovr));
endmodule

// File: rtl/ts_read_port.sv
// Register read port. A status read freezes a snapshot of the stamp so
// the following field reads form one consistent tuple. Assumes
// FIELD_W >= 3 so that the status bits fit.
module ts_read_port
    import ts_pkg::*;
#(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 6,
    parameter int ADDR_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          flag,
    input  logic                          ovr,
    input  logic                          mode_full,
    input  logic [NUM_FIELDS*FIELD_W-1:0] stamp,
    output logic [FIELD_W-1:0]            rd_data
);
    localparam int SLOTS = 1 << ADDR_W;

    logic [NUM_FIELDS*FIELD_W-1:0] snap_q;
    logic [FIELD_W-1:0]            slot [SLOTS];
    logic [FIELD_W-1:0]            status_w;
    logic [ADDR_W-1:0]             slot_idx;

    // Split the snapshot into field slots; unused slots read as zero.
    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            if (i < NUM_FIELDS) begin : g_used
                assign slot[i] = snap_q[i*FIELD_W +: FIELD_W];
            end else begin : g_empty
                assign slot[i] = '0;
            end
        end
    endgenerate

    // Assemble the status word.
    always_comb begin
        status_w              = '0;
        status_w[ST_FLAG_BIT] = flag;
        status_w[ST_OVR_BIT]  = ovr;
        status_w[ST_MODE_BIT] = mode_full;
    end

    assign slot_idx = rd_addr - 1'b1;

    // Register read data and take the snapshot on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '0;
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_addr == '0) begin
                rd_data <= status_w;
                snap_q  <= stamp;
            end else begin
                rd_data <= slot[slot_idx];
            end
        end
    end

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == '0) |=> $stable(snap_q));
endmodule

// File: rtl/evt_stamp_latch.sv
// Top of the event timestamp latch: synchronizer, tick shadow,
// single-entry store and read port. Assumes tick marks cycles in which
// cal_bus and sec_cnt hold a coherent time.
module evt_stamp_latch #(
    parameter int FIELD_W     = 8,
    parameter int NUM_FIELDS  = 6,
    parameter int SEC_W       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int STAMP_W    = NUM_FIELDS * FIELD_W,
    localparam int ADDR_W     = $clog2(NUM_FIELDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_in,
    input  logic               tick,
    input  logic [STAMP_W-1:0] cal_bus,
    input  logic [SEC_W-1:0]   sec_cnt,
    input  logic               full_cal,
    input  logic               keep_latest,
    input  logic               clr,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [FIELD_W-1:0] rd_data,
    output logic               irq
);
    logic               cap;
    logic               flag;
    logic               ovr;
    logic               mode_full;
    logic [STAMP_W-1:0] stamp;
    logic [STAMP_W-1:0] cal_shadow;
    logic [SEC_W-1:0]   sec_shadow;

    ts_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .evt_async(evt_in), .evt_rise(cap)
    );

    ts_tick_shadow #(.STAMP_W(STAMP_W), .SEC_W(SEC_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cal_bus(cal_bus),
        .sec_cnt(sec_cnt), .cal_shadow(cal_shadow), .sec_shadow(sec_shadow)
    );

    ts_stamp_store #(.STAMP_W(STAMP_W), .SEC_W(SEC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cap(cap), .clr(clr),
        .keep_latest(keep_latest), .full_cal(full_cal),
        .cal_shadow(cal_shadow), .sec_shadow(sec_shadow),
        .flag(flag), .ovr(ovr), .mode_full(mode_full), .stamp(stamp)
    );

    ts_read_port #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS),
                   .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .flag(flag), .ovr(ovr), .mode_full(mode_full), .stamp(stamp),
        .rd_data(rd_data)
    );

    // Interrupt is the level of the timestamp flag.
    assign irq = flag;

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
endmodule

// File: tb/evt_stamp_latch_test.sv
module evt_stamp_latch_test;
    localparam int FW = 8;
    localparam int NF = 6;
    localparam int SW = 32;
    localparam int STW = NF * FW;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_in = 1'b0, tick = 1'b0, full_cal = 1'b1, keep_latest = 1'b0;
    logic clr = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [STW-1:0] cal_bus = '0;
    logic [SW-1:0] sec_cnt = '0;
    logic [FW-1:0] rd_data;
    logic irq;

    int checks = 0;
    int failures = 0;

    // Model state derived from the requirements.
    logic [STW-1:0] m_cal, m_stamp;
    logic [SW-1:0]  m_sec;
    logic m_flag, m_ovr, m_mode;

    evt_stamp_latch uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick(tick),
        .cal_bus(cal_bus), .sec_cnt(sec_cnt), .full_cal(full_cal),
        .keep_latest(keep_latest), .clr(clr), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [STW-1:0] exp_stamp(input logic full,
            input logic [STW-1:0] c, input logic [SW-1:0] s);
        return full ? c : STW'(s);
    endfunction

    function automatic logic [FW-1:0] exp_status(input logic f,
            input logic o, input logic m);
        return FW'({m, o, f});
    endfunction

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [FW-1:0] d);
        rd_en = 1'b1; rd_addr = a;
        cyc(1);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Present a new time with a tick, then scramble the bus without one (R4).
    task automatic load_time(input logic [STW-1:0] c, input logic [SW-1:0] s);
        cal_bus = c; sec_cnt = s; tick = 1'b1;
        cyc(1);
        tick = 1'b0;
        m_cal = c; m_sec = s;
        cal_bus = {$urandom, $urandom};
        sec_cnt = $urandom;
    endtask

    task automatic model_event();
        if (!m_flag) begin
            m_flag = 1'b1; m_ovr = 1'b0;
            m_stamp = exp_stamp(full_cal, m_cal, m_sec); m_mode = full_cal;
        end else begin
            m_ovr = 1'b1;
            if (keep_latest) begin
                m_stamp = exp_stamp(full_cal, m_cal, m_sec); m_mode = full_cal;
            end
        end
    endtask

    task automatic fire();
        evt_in = 1'b1;
        cyc(4);
        evt_in = 1'b0;
        cyc(3);
        model_event();
    endtask

    task automatic do_clr();
        clr = 1'b1; cyc(1); clr = 1'b0;
        m_flag = 1'b0; m_ovr = 1'b0;
    endtask

    // Status read (takes snapshot) then every field against the model.
    task automatic read_all(input string req);
        logic [FW-1:0] d;
        rd(0, d);
        chk({req, " status"}, d, exp_status(m_flag, m_ovr, m_mode));
        for (int k = 0; k < NF; k++) begin
            rd(AW'(k + 1), d);
            chk({req, " field"}, d, m_stamp[k*FW +: FW]);
        end
    endtask

    initial begin
        logic [FW-1:0] d;
        logic [STW-1:0] snap_old;
        void'($urandom(32'h5EED));
        m_cal = '0; m_sec = '0; m_stamp = '0;
        m_flag = 0; m_ovr = 0; m_mode = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 irq", irq, 0);
        read_all("R1");
        rd(7, d); chk("R1 addr7", d, 0);

        // R2 latency: flag on third edge, level held gives one capture
        full_cal = 1'b1;
        load_time(48'h1122_3344_5566, 32'hA5A5_0001);
        evt_in = 1'b1;
        cyc(2); chk("R2 before third edge", irq, 0);
        cyc(1); chk("R2 at third edge", irq, 1);
        cyc(6);
        evt_in = 1'b0; cyc(3);
        model_event();
        // R3 calendar content, R4 scrambled bus ignored, R2 no overrun
        read_all("R2_R3_R4");

        // R5 irq held, then clear
        cyc(5); chk("R5 irq held", irq, 1);
        do_clr();
        chk("R5 irq after clr", irq, 0);
        read_all("R8 clr");

        // R3 seconds mode
        full_cal = 1'b0;
        load_time(48'hFFFF_FFFF_FFFF, 32'hDEAD_BEEF);
        fire();
        read_all("R3 seconds");

        // R6 keep first + R8 overrun
        full_cal = 1'b1; keep_latest = 1'b0;
        load_time(48'h0102_0304_0506, 32'h1);
        fire();
        chk("R5 irq overrun", irq, 1);
        read_all("R6_R8");
        do_clr();

        // R7 keep latest
        keep_latest = 1'b1;
        load_time(48'hAAAA_0000_1111, 32'h2);
        fire();
        load_time(48'hBBBB_2222_3333, 32'h3);
        fire();
        read_all("R7");

        // R10 snapshot isolation while an overwrite happens
        snap_old = m_stamp;
        rd(0, d);
        chk("R10 status", d, exp_status(m_flag, m_ovr, m_mode));
        load_time(48'hCCCC_4444_5555, 32'h4);
        fire();
        for (int k = 0; k < NF; k++) begin
            rd(AW'(k + 1), d);
            chk("R10 snapshot field", d, snap_old[k*FW +: FW]);
        end
        read_all("R10 fresh");
        rd(7, d); chk("R10 addr7", d, 0);
        do_clr();
        keep_latest = 1'b0;

        // R9 clear colliding with capture
        load_time(48'h1010_2020_3030, 32'h5);
        fire();
        load_time(48'h4040_5050_6060, 32'h6);
        evt_in = 1'b1;
        cyc(2);
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk("R9 irq", irq, 1);
        evt_in = 1'b0; cyc(3);
        m_flag = 1'b1; m_ovr = 1'b0; m_mode = 1'b1;
        m_stamp = m_cal;
        read_all("R9");
        do_clr();

        // Random mix
        for (int it = 0; it < 150; it++) begin
            int nev;
            full_cal = $urandom_range(0, 1);
            keep_latest = $urandom_range(0, 1);
            nev = $urandom_range(1, 3);
            for (int e = 0; e < nev; e++) begin
                load_time({$urandom, $urandom}, $urandom);
                fire();
                if ($urandom_range(0, 5) == 0) do_clr();
            end
            chk("R5 random irq", irq, m_flag);
            read_all("R6_R7_R8 random");
            do_clr();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule